// File: doc/BRIEF.md
# Two-Channel DC Offset Correction Loop

This block removes the DC component from two independent streams of signed 14-bit converter samples. Each channel keeps a wide accumulator that acts as a first-order leaky integrator. The top 14 bits of that accumulator are the running DC estimate. The integrator behaves as a high-pass filter. Its corner frequency is picked by a 4-bit shift value `k`. Each step of `k` halves the bandwidth: the bandwidth is the sample rate times 2^-(k+B) over 2π, where B is the base shift (14 by default).

One 7-bit control word configures both channels. It holds two routing enables, a freeze bit and the shift field. One enable subtracts the estimate from the data sent to the signal-monitor path. The other subtracts it from the main output path. Freezing keeps the current estimate in use without updating it. The estimate of each channel is always visible on its own readback port.

A shared three-state controller sets what the accumulators do:

- **OFF**: neither enable is set. The accumulators are cleared and held at zero.
- **TRACK**: at least one enable is set and freeze is clear. Every valid sample updates the accumulators.
- **HOLD**: at least one enable is set and freeze is set. The accumulators keep their value.

The transitions are:

- **enable** (OFF→TRACK or OFF→HOLD, depending on freeze).
- **freeze** (TRACK→HOLD).
- **release** (HOLD→TRACK).
- **disable** (TRACK→OFF or HOLD→OFF, when both enables are clear).

Top module: `dc_offset_corrector`

## Requirements
- R1: A synchronous active-high reset clears both accumulators, both estimates, all data outputs and `out_valid`, and puts the controller in OFF.
- R2: Control word fields are: bit 0 = monitor-path enable, bit 1 = output-path enable, bits [5:2] = shift `k`, bit 6 = freeze. The controller registers the word on one clock edge. The new value governs samples accepted from the following edge on.
- R3: The controller follows the OFF/TRACK/HOLD states and the enable, freeze, release and disable transitions named above. On release, tracking resumes from the held value.
- R4: In TRACK, each valid sample x updates the accumulator: acc += ((x << F) − acc) >>> (k + B), with F = B + 13 fractional bits. The estimate is acc's top 14 bits. The estimate never steps past the sample in either direction.
- R5: A shift value of 14 or 15 gives exactly the same results as 13.
- R6: In HOLD the accumulator does not change, and the held estimate is still applied to the enabled paths.
- R7: In OFF the accumulator is cleared to zero, so the readback estimate reads 0.
- R8: `out_a`/`out_b` carry sat(x − est) when the output enable is set, and x otherwise. The estimate used is the value before this sample's update. The result is registered, so it appears one edge after the sample. `out_valid` is `in_valid` delayed by one edge.
- R9: `mon_a`/`mon_b` follow the same rule as R8, selected by the monitor enable instead of the output enable.
- R10: Corrected values saturate to the signed 14-bit range −8192..8191.
- R11: The two channels are independent. Each channel's estimate depends only on its own samples and is read on `est_a`/`est_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 7 | Control word (fields in R2) |
| in_valid | input | 1 | Sample strobe for both channels |
| in_a | input | 14 | Channel A sample, signed |
| in_b | input | 14 | Channel B sample, signed |
| out_valid | output | 1 | Output samples valid |
| out_a | output | 14 | Channel A output-path sample |
| out_b | output | 14 | Channel B output-path sample |
| mon_a | output | 14 | Channel A monitor-path sample |
| mon_b | output | 14 | Channel B monitor-path sample |
| est_a | output | 14 | Channel A DC estimate readback |
| est_b | output | 14 | Channel B DC estimate readback |

## Verification
The bench drives each shift value against a bit-exact model of the update rule, and checks that shift values 14 and 15 match 13. A design that failed to clamp would show an estimate that creeps up visibly slower.

Freeze is held while the input jumps, to catch a design that keeps integrating. It is then released, to catch one that stays stuck.

The two enables are swept one at a time. This exposes a crossed route between the monitor and output paths.

Both channels are driven close to full scale, then the input is flipped to the opposite rail. This catches a design that wraps around instead of saturating.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_TRACK = 2'd1,
        ST_HOLD  = 2'd2
    } dcc_state_e;

    typedef struct packed {
        logic       freeze;
        logic [3:0] shift;
        logic       out_en;
        logic       mon_en;
    } dcc_ctrl_t;

endpackage

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
    import dcc_pkg::*;
#(
    parameter int KW   = 4,
    parameter int KMAX = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  dcc_ctrl_t     ctrl,
    output dcc_state_e    state,
    output logic [KW-1:0] k_eff,
    output logic          apply_out,
    output logic          apply_mon,
    output logic          run,
    output logic          clear
);

    dcc_state_e    state_nx;
    logic          any_en;
    logic [KW-1:0] k_clamped;

    assign any_en    = ctrl.mon_en | ctrl.out_en;
    assign k_clamped = (ctrl.shift > KW'(KMAX)) ? KW'(KMAX) : ctrl.shift;

    // next-state logic: enable / freeze / release / disable
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (any_en) state_nx = ctrl.freeze ? ST_HOLD : ST_TRACK;
            end
            ST_TRACK: begin
                if (!any_en)          state_nx = ST_OFF;
                else if (ctrl.freeze) state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (!any_en)           state_nx = ST_OFF;
                else if (!ctrl.freeze) state_nx = ST_TRACK;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // state and captured control fields
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_OFF;
            k_eff     <= '0;
            apply_out <= 1'b0;
            apply_mon <= 1'b0;
        end else begin
            state     <= state_nx;
            k_eff     <= k_clamped;
            apply_out <= ctrl.out_en;
            apply_mon <= ctrl.mon_en;
        end
    end

    // per-state actions for the accumulators
    always_comb begin
        run   = 1'b0;
        clear = 1'b0;
        unique case (state)
            ST_OFF:   clear = 1'b1;
            ST_TRACK: run   = 1'b1;
            ST_HOLD:  ;
            default:  clear = 1'b1;
        endcase
    end

    a_r3_off_entry: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.mon_en || ctrl.out_en) |=> (state == ST_OFF));

    a_r3_freeze_entry: assert property (@(posedge clk) disable iff (rst)
        ((ctrl.mon_en || ctrl.out_en) && ctrl.freeze) |=> (state == ST_HOLD));

endmodule

// File: rtl/dcc_chan.sv
module dcc_chan #(
    parameter int W    = 14,
    parameter int SB   = 14,
    parameter int KW   = 4,
    parameter int KMAX = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] x,
    input  logic                run,
    input  logic                clear,
    input  logic [KW-1:0]       k_eff,
    input  logic                apply_out,
    input  logic                apply_mon,
    output logic signed [W-1:0] out_y,
    output logic signed [W-1:0] mon_y,
    output logic signed [W-1:0] est
);

    localparam int FRAC = SB + KMAX;
    localparam int AW   = W + FRAC;

    logic signed [AW-1:0] acc;
    logic signed [AW:0]   err;
    logic signed [AW:0]   step;
    logic signed [AW:0]   acc_sum;
    logic signed [W:0]    diff;
    logic signed [W-1:0]  corr;

    assign est = acc[AW-1:FRAC];

    // leaky integrator update
    always_comb begin
        err     = $signed({x[W-1], x, {FRAC{1'b0}}}) - $signed({acc[AW-1], acc});
        step    = err >>> (SB + int'(k_eff));
        acc_sum = $signed({acc[AW-1], acc}) + step;
    end

    // subtract estimate with saturation
    always_comb begin
        diff = $signed({x[W-1], x}) - $signed({est[W-1], est});
        if (diff > $signed({2'b00, {(W-1){1'b1}}}))
            corr = {1'b0, {(W-1){1'b1}}};
        else if (diff < $signed({2'b11, {(W-1){1'b0}}}))
            corr = {1'b1, {(W-1){1'b0}}};
        else
            corr = diff[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            out_y <= '0;
            mon_y <= '0;
        end else begin
            if (clear)
                acc <= '0;
            else if (run && in_valid)
                acc <= acc_sum[AW-1:0];
            if (in_valid) begin
                out_y <= apply_out ? corr : x;
                mon_y <= apply_mon ? corr : x;
            end
        end
    end

    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (run && in_valid) |-> (acc_sum[AW] == acc_sum[AW-1]));

    a_r4_no_overshoot: assert property (@(posedge clk) disable iff (rst)
        (run && in_valid && !clear) |=>
            ((est >= $past(est)) || (est >= $past(x))) &&
            ((est <= $past(est)) || (est <= $past(x))));

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(acc));

    a_r7_off_clear: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc == '0));

endmodule

// File: rtl/dc_offset_corrector.sv
module dc_offset_corrector
    import dcc_pkg::*;
#(
    parameter int W          = 14,
    parameter int SHIFT_BASE = 14,
    parameter int KW         = 4,
    parameter int KMAX       = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [6:0]          ctrl,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_a,
    input  logic signed [W-1:0] in_b,
    output logic                out_valid,
    output logic signed [W-1:0] out_a,
    output logic signed [W-1:0] out_b,
    output logic signed [W-1:0] mon_a,
    output logic signed [W-1:0] mon_b,
    output logic signed [W-1:0] est_a,
    output logic signed [W-1:0] est_b
);

    localparam int NCH = 2;

    dcc_ctrl_t     ctrl_s;
    dcc_state_e    state;
    logic [KW-1:0] k_eff;
    logic          apply_out;
    logic          apply_mon;
    logic          run;
    logic          clear;

    logic signed [W-1:0] x_v   [NCH];
    logic signed [W-1:0] out_v [NCH];
    logic signed [W-1:0] mon_v [NCH];
    logic signed [W-1:0] est_v [NCH];

    assign ctrl_s = dcc_ctrl_t'(ctrl);

    dcc_ctrl #(.KW(KW), .KMAX(KMAX)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_s),
        .state     (state),
        .k_eff     (k_eff),
        .apply_out (apply_out),
        .apply_mon (apply_mon),
        .run       (run),
        .clear     (clear)
    );

    assign x_v[0] = in_a;
    assign x_v[1] = in_b;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dcc_chan #(.W(W), .SB(SHIFT_BASE), .KW(KW), .KMAX(KMAX)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid),
            .x         (x_v[ch]),
            .run       (run),
            .clear     (clear),
            .k_eff     (k_eff),
            .apply_out (apply_out),
            .apply_mon (apply_mon),
            .out_y     (out_v[ch]),
            .mon_y     (mon_v[ch]),
            .est       (est_v[ch])
        );
    end

    assign out_a = out_v[0];
    assign out_b = out_v[1];
    assign mon_a = mon_v[0];
    assign mon_b = mon_v[1];
    assign est_a = est_v[0];
    assign est_b = est_v[1];

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    a_r8_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r8_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_state_legal: assert property (@(posedge clk) disable iff (rst)
        (state != ST_OFF) |-> (apply_out || apply_mon));

endmodule

// File: tb/tb_dc_offset_corrector.sv
module tb_dc_offset_corrector;

    localparam int SB = 2;
    localparam int F  = SB + 13;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [6:0]        ctrl = '0;
    logic              in_valid = 1'b0;
    logic signed [13:0] in_a = '0, in_b = '0;
    logic              out_valid;
    logic signed [13:0] out_a, out_b, mon_a, mon_b, est_a, est_b;

    int nchk  = 0;
    int nfail = 0;

    longint accm [2];
    int     m_mode;   // 0 off, 1 track, 2 hold
    int     m_k;
    bit     m_mon, m_out;

    always #10 clk = ~clk;

    dc_offset_corrector #(.SHIFT_BASE(SB)) dut (
        .clk(clk), .rst(rst), .ctrl(ctrl), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_a(out_a), .out_b(out_b), .mon_a(mon_a), .mon_b(mon_b),
        .est_a(est_a), .est_b(est_b)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat14(input longint v);
        if (v > 8191)  return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    task automatic set_ctrl(input bit mon, input bit oen, input int k, input bit frz);
        ctrl   = {frz, 4'(k), oen, mon};
        m_mon  = mon;
        m_out  = oen;
        m_k    = (k > 13) ? 13 : k;
        m_mode = (!mon && !oen) ? 0 : (frz ? 2 : 1);
        repeat (2) begin
            @(posedge clk);
            @(negedge clk);
        end
        if (m_mode == 0) begin
            accm[0] = 0;
            accm[1] = 0;
        end
    endtask

    task automatic feed(input int xa, input int xb, input string req);
        longint xs [2];
        longint eo [2];
        longint em [2];
        longint eb, c;
        xs[0] = xa;
        xs[1] = xb;
        for (int ch = 0; ch < 2; ch++) begin
            eb = accm[ch] >>> F;
            c  = sat14(xs[ch] - eb);
            eo[ch] = m_out ? c : xs[ch];
            em[ch] = m_mon ? c : xs[ch];
            if (m_mode == 1)
                accm[ch] = accm[ch] + (((xs[ch] <<< F) - accm[ch]) >>> (SB + m_k));
            else if (m_mode == 0)
                accm[ch] = 0;
        end
        in_valid = 1'b1;
        in_a = 14'(xa);
        in_b = 14'(xb);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, {req, " R8 out_valid"}, longint'(out_valid), 1);
        chk(longint'(out_a) == eo[0], {req, " out_a"}, longint'(out_a), eo[0]);
        chk(longint'(out_b) == eo[1], {req, " out_b"}, longint'(out_b), eo[1]);
        chk(longint'(mon_a) == em[0], {req, " mon_a"}, longint'(mon_a), em[0]);
        chk(longint'(mon_b) == em[1], {req, " mon_b"}, longint'(mon_b), em[1]);
        chk(longint'(est_a) == (accm[0] >>> F), {req, " est_a R11"}, longint'(est_a), accm[0] >>> F);
        chk(longint'(est_b) == (accm[1] >>> F), {req, " est_b R11"}, longint'(est_b), accm[1] >>> F);
    endtask

    task automatic t_reset();
        chk(out_valid === 1'b0, "R1 out_valid", longint'(out_valid), 0);
        chk(est_a == 0 && est_b == 0, "R1 estimates", longint'(est_a), 0);
        chk(out_a == 0 && mon_b == 0, "R1 outputs", longint'(out_a), 0);
    endtask

    task automatic t_track();
        set_ctrl(1, 1, 0, 0);
        for (int i = 0; i < 40; i++) feed(1000, -2500, "R4 k0");
        set_ctrl(1, 1, 3, 0);
        for (int i = 0; i < 60; i++) feed(-300 + i, 4000 - 7 * i, "R4 k3");
        set_ctrl(1, 1, 13, 0);
        for (int i = 0; i < 30; i++) feed(8191, -8192, "R4 k13");
    endtask

    task automatic t_clamp();
        set_ctrl(0, 0, 0, 0);
        set_ctrl(1, 1, 15, 0);
        for (int i = 0; i < 200; i++) feed(8191, -8192, "R5 k15");
        chk(est_a > 20, "R5 k15 progress", longint'(est_a), 21);
        set_ctrl(1, 1, 14, 0);
        for (int i = 0; i < 50; i++) feed(-5000, 5000, "R5 k14");
    endtask

    task automatic t_freeze();
        longint held;
        set_ctrl(0, 0, 0, 0);
        chk(est_a == 0 && est_b == 0, "R7 off clears", longint'(est_a), 0);
        set_ctrl(1, 1, 0, 0);
        for (int i = 0; i < 50; i++) feed(2000, -1200, "R4 pre-freeze");
        held = longint'(est_a);
        set_ctrl(1, 1, 0, 1);
        for (int i = 0; i < 20; i++) feed(-6000, 6000, "R6 hold");
        chk(longint'(est_a) == held, "R6 held estimate", longint'(est_a), held);
        set_ctrl(1, 1, 0, 0);
        for (int i = 0; i < 20; i++) feed(-6000, 6000, "R3 release");
        chk(longint'(est_a) < held, "R3 tracking resumed", longint'(est_a), held - 1);
    endtask

    task automatic t_routes();
        set_ctrl(1, 0, 1, 0);
        for (int i = 0; i < 20; i++) feed(700, -700, "R9 monitor only");
        set_ctrl(0, 1, 1, 0);
        for (int i = 0; i < 20; i++) feed(-700, 700, "R2 output only");
        set_ctrl(0, 0, 1, 0);
        for (int i = 0; i < 5; i++) feed(1234, -4321, "R7 off raw");
    endtask

    task automatic t_sat();
        set_ctrl(1, 1, 0, 0);
        for (int i = 0; i < 80; i++) feed(8000, -8000, "R10 settle");
        feed(-8192, 8191, "R10 rail flip");
        chk(out_a == -14'sd8192 && out_b == 14'sd8191, "R10 saturated", longint'(out_a), -8192);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 10000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        accm[0] = 0;
        accm[1] = 0;
        m_mode  = 0;
        m_k     = 0;
        m_mon   = 0;
        m_out   = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_track();
        t_clamp();
        t_freeze();
        t_routes();
        t_sat();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule